// File: doc/BRIEF.md
# Packed Signed Narrowing Unit with Saturation

This block takes two packed vectors of signed integers and narrows every element to half its width. The narrowed elements of both sources are then combined into one packed result. Any element that does not fit in the narrower signed type is clamped to the most positive or most negative value of that type. Two element kinds are supported: 16-bit elements narrowed to 8 bits, and 32-bit elements narrowed to 16 bits. Three vector sizes are supported: 64, 128 and 256 bits.

The caller supplies both sources, the previous contents of the destination, a mode and a valid strobe. The result is registered and leaves the block one clock later with its own valid strobe. The bits above the active vector width are either copied from the previous destination or cleared, depending on the mode. In 256-bit mode each 128-bit half of the vectors is packed independently, so the two halves of the result are interleaved rather than formed by simple concatenation. The operation has no flags and no exceptions.

Top module: `pack_sat_unit`

## Requirements
- R1: With `in_kind` = 0 (16 to 8), each signed 16-bit element greater than 127 gives 8'h7F. Each element less than -128 gives 8'h80. Any other element gives its low byte.
- R2: With `in_kind` = 1 (32 to 16), each signed 32-bit element greater than 32767 gives 16'h7FFF. Each element less than -32768 gives 16'h8000. Any other element gives its low 16 bits.
- R3: With `in_size` = 2'b01 (128-bit), result bits 63:0 hold the narrowed elements of `src_a[127:0]` in ascending element order. Result bits 127:64 hold those of `src_b[127:0]`, also in ascending order.
- R4: With `in_size` = 2'b10 (256-bit), bits 127:0 of the result are packed from `src_a[127:0]` (low 64 bits) and `src_b[127:0]` (high 64 bits). Bits 255:128 of the result are packed in the same way from `src_a[255:128]` and `src_b[255:128]`.
- R5: With `in_size` = 2'b00 (64-bit), result bits 31:0 are narrowed from `src_a[63:0]` and bits 63:32 from `src_b[63:0]`. Bits 255:64 equal `old_dst[255:64]`, and `in_zero_hi` has no effect.
- R6: In 128-bit mode with `in_zero_hi` = 0, result bits 255:128 equal `old_dst[255:128]`.
- R7: In 128-bit mode with `in_zero_hi` = 1, result bits 255:128 are zero.
- R8: In 256-bit mode, neither `old_dst` nor `in_zero_hi` has any effect on the result.
- R9: `out_valid` equals `in_valid` from the previous clock. `out_data` is updated only in a cycle that follows an accepted `in_valid`, and otherwise holds its value.
- R10: While the synchronous active-high `rst` is high, at each clock `out_valid` and `out_data` are cleared to zero.
- R11: The reserved `in_size` code 2'b11 behaves exactly like 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| in_size | input | 2 | Vector size: 00 = 64, 01 = 128, 10/11 = 256 |
| in_kind | input | 1 | 0 = 16 to 8 bits, 1 = 32 to 16 bits |
| in_zero_hi | input | 1 | 128-bit mode only: 1 clears bits 255:128, 0 keeps them |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| old_dst | input | 256 | Previous destination contents |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_data | output | 256 | Registered packed result |

## Verification
The block has a single register stage, so a wrong lane route, a wrong saturation threshold or a wrong upper-bit select shows up at `out_data` on the clock right after the request. A bad clamp corrupts only the byte or halfword fed by the element that crosses the threshold. To expose such faults, the 16-to-8 path is swept over every 16-bit value, and the 32-to-16 path is swept densely on both sides of both thresholds. A wrong hold or valid register shows up when `in_valid` drops: either a stale strobe appears or the data moves without a request.

// File: rtl/pack_sat_pkg.sv
package pack_sat_pkg;

    localparam int LANE_W    = 128;
    localparam int NUM_LANES = 2;
    localparam int VEC_W     = LANE_W * NUM_LANES;
    localparam int HALF_W    = LANE_W / 2;
    localparam int QUART_W   = HALF_W / 2;

    typedef enum logic [1:0] {
        SZ_64  = 2'b00,
        SZ_128 = 2'b01,
        SZ_256 = 2'b10,
        SZ_RSV = 2'b11
    } vsize_e;

    typedef enum logic {
        EK_W2B = 1'b0,
        EK_D2W = 1'b1
    } ekind_e;

    typedef struct packed {
        vsize_e size;
        ekind_e kind;
        logic   zero_hi;
    } pmode_t;

    // clamp a signed 16-bit value into signed 8 bits
    function automatic logic [7:0] sat_w2b(input logic [15:0] v);
        if (!v[15] && (v[14:7] != 8'h00))
            return 8'h7F;
        else if (v[15] && (v[14:7] != 8'hFF))
            return 8'h80;
        else
            return v[7:0];
    endfunction

    // clamp a signed 32-bit value into signed 16 bits
    function automatic logic [15:0] sat_d2w(input logic [31:0] v);
        if (!v[31] && (v[30:15] != 16'h0000))
            return 16'h7FFF;
        else if (v[31] && (v[30:15] != 16'hFFFF))
            return 16'h8000;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/pack_narrow.sv
module pack_narrow
    import pack_sat_pkg::*;
#(
    parameter int IN_W = 128
) (
    input  logic [IN_W-1:0]   din,
    input  ekind_e            kind,
    output logic [IN_W/2-1:0] dout
);
    localparam int NUM_W = IN_W / 16;
    localparam int NUM_D = IN_W / 32;

    logic [IN_W/2-1:0] by_bytes;
    logic [IN_W/2-1:0] by_halves;

    for (genvar w = 0; w < NUM_W; w++) begin : g_word
        assign by_bytes[8*w +: 8] = sat_w2b(din[16*w +: 16]);

        // narrowing with clamping never flips an element's sign
        always_comb begin
            if (kind == EK_W2B) begin
                p_sign_kept_r1: assert (dout[8*w+7] == din[16*w+15]);
            end
        end
    end

    for (genvar d = 0; d < NUM_D; d++) begin : g_dword
        assign by_halves[16*d +: 16] = sat_d2w(din[32*d +: 32]);

        always_comb begin
            if (kind == EK_D2W) begin
                p_sign_kept_r2: assert (dout[16*d+15] == din[32*d+31]);
            end
        end
    end

    assign dout = (kind == EK_D2W) ? by_halves : by_bytes;

endmodule

// File: rtl/pack_lane.sv
module pack_lane
    import pack_sat_pkg::*;
(
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    input  ekind_e            kind,
    output logic [LANE_W-1:0] packed_lane
);
    logic [HALF_W-1:0] na;
    logic [HALF_W-1:0] nb;

    pack_narrow #(.IN_W(LANE_W)) u_nar_a (
        .din  (a_lane),
        .kind (kind),
        .dout (na)
    );

    pack_narrow #(.IN_W(LANE_W)) u_nar_b (
        .din  (b_lane),
        .kind (kind),
        .dout (nb)
    );

    assign packed_lane = {nb, na};

endmodule

// File: rtl/pack_sat_unit.sv
module pack_sat_unit
    import pack_sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_size,
    input  logic             in_kind,
    input  logic             in_zero_hi,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] old_dst,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    pmode_t            mode;
    logic [LANE_W-1:0] lane_res [NUM_LANES];
    logic [VEC_W-1:0]  result;

    assign mode.size    = vsize_e'(in_size);
    assign mode.kind    = ekind_e'(in_kind);
    assign mode.zero_hi = in_zero_hi;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        pack_lane u_lane (
            .a_lane      (src_a[l*LANE_W +: LANE_W]),
            .b_lane      (src_b[l*LANE_W +: LANE_W]),
            .kind        (mode.kind),
            .packed_lane (lane_res[l])
        );
    end

    always_comb begin
        result = old_dst;
        case (mode.size)
            SZ_64: begin
                // the low quarter of each lane half comes from the low 64 source bits
                result[HALF_W-1:0] = {lane_res[0][HALF_W +: QUART_W],
                                      lane_res[0][0 +: QUART_W]};
            end
            SZ_128: begin
                if (mode.zero_hi)
                    result = '0;
                result[LANE_W-1:0] = lane_res[0];
            end
            default: begin
                for (int l = 0; l < NUM_LANES; l++)
                    result[l*LANE_W +: LANE_W] = lane_res[l];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= result;
        end
    end

    p_valid_lag_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_data));

    p_pass_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b00)
        |=> (out_data[VEC_W-1:HALF_W] == $past(old_dst[VEC_W-1:HALF_W])));

    p_keep_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b01 && !in_zero_hi)
        |=> (out_data[VEC_W-1:LANE_W] == $past(old_dst[VEC_W-1:LANE_W])));

    p_zero_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b01 && in_zero_hi)
        |=> (out_data[VEC_W-1:LANE_W] == '0));

endmodule

// File: tb/tb_pack_sat_unit.sv
`timescale 1ns/1ps
module tb_pack_sat_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_size = 2'b00;
    logic         in_kind = 1'b0;
    logic         in_zero_hi = 1'b0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [255:0] old_dst = '0;
    logic         out_valid;
    logic [255:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0]  xs = 64'h9E3779B97F4A7C15;
    logic [255:0] last_exp = '0;

    always #2 clk = ~clk;

    pack_sat_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_kind(in_kind), .in_zero_hi(in_zero_hi), .src_a(src_a),
        .src_b(src_b), .old_dst(old_dst), .out_valid(out_valid),
        .out_data(out_data)
    );

    function automatic logic [7:0] ref_b(input logic [15:0] v);
        int s = int'($signed(v));
        if (s > 127) return 8'h7F;
        if (s < -128) return 8'h80;
        return v[7:0];
    endfunction

    function automatic logic [15:0] ref_h(input logic [31:0] v);
        longint s = longint'($signed(v));
        if (s > 32767) return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    // one 128-bit lane: narrowed x below narrowed y
    function automatic logic [127:0] ref_lane(input logic [127:0] x, input logic [127:0] y, input logic k);
        logic [127:0] r;
        if (!k) begin
            for (int j = 0; j < 8; j++) begin
                r[8*j +: 8]      = ref_b(x[16*j +: 16]);
                r[64 + 8*j +: 8] = ref_b(y[16*j +: 16]);
            end
        end else begin
            for (int j = 0; j < 4; j++) begin
                r[16*j +: 16]      = ref_h(x[32*j +: 32]);
                r[64 + 16*j +: 16] = ref_h(y[32*j +: 32]);
            end
        end
        return r;
    endfunction

    function automatic logic [255:0] model(input logic [1:0] sz, input logic k, input logic zh,
                                           input logic [255:0] a, input logic [255:0] b,
                                           input logic [255:0] od);
        logic [127:0] lo = ref_lane(a[127:0], b[127:0], k);
        logic [127:0] hi = ref_lane(a[255:128], b[255:128], k);
        case (sz)
            2'b00:   return {od[255:64], lo[95:64], lo[31:0]};
            2'b01:   return {(zh ? 128'd0 : od[255:128]), lo};
            default: return {hi, lo};
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] sz, input logic zh);
        case (sz)
            2'b00:   return "R5";
            2'b01:   return zh ? "R7" : "R6";
            2'b10:   return "R4 R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    task automatic rnd_vec(output logic [255:0] v);
        for (int k = 0; k < 8; k++) begin
            xs = step(xs);
            v[32*k +: 32] = 32'($signed(xs[31:0]) >>> xs[36:32]);
        end
    endtask

    task automatic run_op(input logic [1:0] sz, input logic k, input logic zh,
                          input logic [255:0] a, input logic [255:0] b,
                          input logic [255:0] od, input string tag);
        logic [255:0] e = model(sz, k, zh, a, b, od);
        in_valid = 1'b1; in_size = sz; in_kind = k; in_zero_hi = zh;
        src_a = a; src_b = b; old_dst = od;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b1 || out_data !== e) begin
            n_bad++;
            $display("FAIL %s: got v=%b d=%h exp v=1 d=%h", tag, out_valid, out_data, e);
        end
        last_exp = e;
    endtask

    task automatic check_idle(input logic [255:0] e, input string tag);
        n_cmp++;
        if (out_valid !== 1'b0 || out_data !== e) begin
            n_bad++;
            $display("FAIL %s: got v=%b d=%h exp v=0 d=%h", tag, out_valid, out_data, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] a, b, od;
        repeat (3) @(negedge clk);
        check_idle('0, "R10 reset state");
        rst = 1'b0;

        // R1 R3: every 16-bit value appears once across the sweep
        for (int t = 0; t < 4096; t++) begin
            a = {8{32'hA5A5_5A5A}};
            b = {8{32'h1234_5678}};
            for (int j = 0; j < 8; j++) begin
                a[16*j +: 16] = 16'(t*16 + j);
                b[16*j +: 16] = 16'(t*16 + 8 + j);
            end
            run_op(2'b01, 1'b0, 1'b1, a, b, {8{32'hDEAD_BEEF}}, "R1 R3 R7");
        end

        // R2 R3: dense window around both 32-to-16 thresholds
        for (int t = 0; t < 2048; t++) begin
            a = {8{32'h0F0F_F0F0}};
            b = {8{32'h3C3C_C3C3}};
            for (int j = 0; j < 4; j++) begin
                int off = t*4 + j - 4096;
                a[32*j +: 32] = 32'h0000_7FFF + 32'(off);
                b[32*j +: 32] = 32'hFFFF_8000 + 32'(off);
            end
            run_op(2'b01, 1'b1, 1'b0, a, b, {8{32'hCAFE_F00D}}, "R2 R3 R6");
        end

        // R2 R5: extreme values in 64-bit mode, zero_hi set but must not matter
        a = '0; b = '0;
        a[63:0] = {32'h7FFF_FFFF, 32'h8000_0000};
        b[63:0] = {32'hFFFF_FFFF, 32'h0001_0000};
        run_op(2'b00, 1'b1, 1'b1, a, b, {8{32'h5555_AAAA}}, "R2 R5 extremes");

        // R8: same sources in 256-bit mode with differing old_dst and zero_hi
        rnd_vec(a); rnd_vec(b);
        run_op(2'b10, 1'b0, 1'b0, a, b, '1, "R8 a");
        run_op(2'b10, 1'b0, 1'b1, a, b, '0, "R8 b");
        run_op(2'b11, 1'b1, 1'b1, a, b, '1, "R11 reserved size");

        // mixed random traffic across every mode
        for (int t = 0; t < 3000; t++) begin
            logic [1:0] sz = 2'(t % 4);
            logic k = t[2];
            logic zh = t[3];
            rnd_vec(a); rnd_vec(b); rnd_vec(od);
            run_op(sz, k, zh, a, b, od,
                   {mode_tag(sz, zh), (k ? " R2" : " R1")});
        end

        // R9: no request -> strobe low and data held despite new inputs
        in_valid = 1'b0;
        rnd_vec(a); src_a = a; src_b = ~a; in_size = 2'b10;
        @(negedge clk);
        check_idle(last_exp, "R9 hold 1");
        @(negedge clk);
        check_idle(last_exp, "R9 hold 2");

        // R10: reset in mid-run clears the output
        run_op(2'b01, 1'b0, 1'b0, a, ~a, a, "R3 R6 pre-reset");
        rst = 1'b1;
        @(negedge clk);
        check_idle('0, "R10 mid-run reset");
        rst = 1'b0;
        run_op(2'b00, 1'b0, 1'b0, a, ~a, ~a, "R5 R9 after reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule